// File: doc/BRIEF.md
# Bus Ownership Tracker

This block follows who holds the external bus from the point of view of one processor's bus interface. On every rising bus clock it samples the arbiter's grant, the processor's own internal request, a transfer-start input seen from another master, the bus-busy level that other masters drive, and a strobe that marks the end of a bus cycle. From these it keeps one of five states. In idle the bus belongs to nobody. In parked the grant rests here with no transfer running. In owning the processor runs its own cycles. In snooping another master's transfer is being watched. The violation state is entered when another master drives busy while this processor holds the bus.

The state decides whether the processor drives its bus-busy line or leaves it three-stated. A separate enable carries that choice so the pad can three-state the line. The block also holds the external arbiter's request register, which delays the internal request by a set number of bus clocks. It forms the wired bus-busy level that the whole system sees. Any cycle termination counts as the end of a cycle: normal, bus error or retry. A burst that falls back to single transfers and a locked sequence count as ordinary cycles, with one end strobe per transaction.

Top module: `bus_own_tracker`

## Requirements
- R1: A synchronous active-high reset puts the block in idle (state code 0) on the next rising edge, with bus-busy three-stated (enable 0, value 0), the violation flag clear and the request register cleared.
- R2: In idle (0) or parked (1), grant with internal request and bus-busy-in low moves the block to owning (code 2) on the next edge, and bus-busy is then driven high with its enable set.
- R3: In idle, grant with transfer-start-in low and bus-busy-in low, but no internal request, moves the block to parked (code 1) with bus-busy three-stated. Any other input combination not covered by R2 or R4 keeps it idle.
- R4: In idle or parked, no grant together with transfer-start-in moves the block to snooping (code 3) with bus-busy three-stated.
- R5: In owning, an end strobe without grant releases the bus to idle, whatever the termination kind (end-kind field: 0 normal, 1 bus error, 2 retry, 3 treated as normal).
- R6: In owning, an end strobe with grant and end-kind 1 (bus error) keeps the block in owning.
- R7: In owning, an end strobe with grant and a kind other than 1 stays in owning while the internal request is high and goes to parked when it is low. Without an end strobe the block stays in owning.
- R8: In owning, bus-busy-in high moves the block to violation (code 4). The violation flag is set, bus-busy is three-stated, and the block stays there whatever the inputs until reset.
- R9: In snooping, an end strobe moves the block to parked if grant is high and to idle otherwise. Without an end strobe it stays in snooping.
- R10: In parked, losing grant with transfer-start-in low returns the block to idle. With grant held and no request it stays parked.
- R11: The external request output equals the internal request delayed by REQ_STAGES rising edges (2 by default).
- R12: The system bus-busy output is high whenever bus-busy-in is high or the block drives bus-busy, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| grant_i | input | 1 | Bus grant from the arbiter |
| ireq_i | input | 1 | Internal bus request from the sequencer |
| ts_in_i | input | 1 | Transfer start sampled from another master |
| bb_in_i | input | 1 | Bus busy driven by another master |
| end_cyc_i | input | 1 | Strobe marking the end of the current bus cycle |
| end_kind_i | input | 2 | Termination kind: 0 normal, 1 bus error, 2 retry, 3 normal |
| bb_out_o | output | 1 | Bus-busy value driven by this processor |
| bb_oe_o | output | 1 | Output enable for bus-busy (0 = three-stated) |
| bb_sys_o | output | 1 | Combined bus-busy seen on the bus |
| br_o | output | 1 | Registered bus request to the external arbiter |
| state_o | output | 3 | Ownership state code (0 idle, 1 parked, 2 owning, 3 snooping, 4 violation) |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest situation to reach is a cycle end in owning where grant is still high and the kind is a bus error. At that point the R6 hold and the R7 park/keep rules differ only in the end-kind field and the request level, so all of them have to be lined up in one cycle. The directed stimulus first reaches owning through a parked state. It then ends cycles with a bus error, a normal end and a retry, with the request high and low. Only after that does it force a violation and prove with toggled inputs that the violation holds until reset. A long random phase with sparse busy-in pulses and periodic resets then reaches the remaining transitions, while a behavioural model is compared on every clock.

// File: rtl/bown_pkg.sv
package bown_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PARK  = 3'd1,
    ST_OWN   = 3'd2,
    ST_SNOOP = 3'd3,
    ST_VIOL  = 3'd4
  } own_st_t;

  typedef enum logic [1:0] {
    END_OK    = 2'd0,
    END_BERR  = 2'd1,
    END_RETRY = 2'd2,
    END_RSVD  = 2'd3
  } end_kind_t;

  // One cycle's worth of sampled bus observations
  typedef struct packed {
    logic grant;
    logic ireq;
    logic ts;
    logic bb_in;
    logic ended;
    logic berr;
  } bus_obs_t;

endpackage

// File: rtl/bown_next.sv
module bown_next
  import bown_pkg::*;
(
  input  own_st_t  cur_st,
  input  bus_obs_t obs,
  output own_st_t  nxt_st
);

  logic take_bus;
  logic may_park;
  logic see_snoop;

  always_comb begin
    take_bus  = obs.grant && obs.ireq && !obs.bb_in;
    may_park  = obs.grant && !obs.ts && !obs.bb_in;
    see_snoop = !obs.grant && obs.ts;
  end

  always_comb begin
    nxt_st = cur_st;
    unique case (cur_st)
      ST_IDLE: begin
        if (take_bus)       nxt_st = ST_OWN;
        else if (may_park)  nxt_st = ST_PARK;
        else if (see_snoop) nxt_st = ST_SNOOP;
      end
      ST_PARK: begin
        if (take_bus)        nxt_st = ST_OWN;
        else if (see_snoop)  nxt_st = ST_SNOOP;
        else if (!obs.grant) nxt_st = ST_IDLE;
      end
      ST_OWN: begin
        if (obs.bb_in)                   nxt_st = ST_VIOL;
        else if (obs.ended && !obs.grant) nxt_st = ST_IDLE;
        else if (obs.ended && obs.berr)   nxt_st = ST_OWN;
        else if (obs.ended && !obs.ireq)  nxt_st = ST_PARK;
      end
      ST_SNOOP: begin
        if (obs.ended) nxt_st = obs.grant ? ST_PARK : ST_IDLE;
      end
      ST_VIOL: nxt_st = ST_VIOL;
      default: nxt_st = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bown_drv.sv
module bown_drv
  import bown_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  own_st_t nxt_st,
  output own_st_t st_q,
  output logic    bb_out_q,
  output logic    bb_oe_q,
  output logic    viol_q
);

  // Outputs are decoded from the next state so that they are
  // registered and aligned with the state register.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      bb_out_q <= 1'b0;
      bb_oe_q  <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      st_q     <= nxt_st;
      bb_out_q <= (nxt_st == ST_OWN);
      bb_oe_q  <= (nxt_st == ST_OWN);
      viol_q   <= (nxt_st == ST_VIOL);
    end
  end

endmodule

// File: rtl/bown_arb_reg.sv
module bown_arb_reg #(
  parameter int REQ_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ireq,
  input  logic bb_in,
  input  logic bb_out,
  input  logic bb_oe,
  output logic br,
  output logic bb_sys
);

  localparam int LAST = REQ_STAGES - 1;

  logic [LAST:0] req_pipe;

  generate
    if (REQ_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) req_pipe <= '0;
        else     req_pipe <= ireq;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) req_pipe <= '0;
        else     req_pipe <= {req_pipe[LAST-1:0], ireq};
      end
    end
  endgenerate

  assign br     = req_pipe[LAST];
  assign bb_sys = bb_in | (bb_oe & bb_out);

endmodule

// File: rtl/bus_own_tracker.sv
module bus_own_tracker
  import bown_pkg::*;
#(
  parameter int REQ_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       grant_i,
  input  logic       ireq_i,
  input  logic       ts_in_i,
  input  logic       bb_in_i,
  input  logic       end_cyc_i,
  input  logic [1:0] end_kind_i,
  output logic       bb_out_o,
  output logic       bb_oe_o,
  output logic       bb_sys_o,
  output logic       br_o,
  output logic [2:0] state_o,
  output logic       viol_o
);

  bus_obs_t obs;
  own_st_t  nxt_st;
  own_st_t  st_q;

  always_comb begin
    obs.grant = grant_i;
    obs.ireq  = ireq_i;
    obs.ts    = ts_in_i;
    obs.bb_in = bb_in_i;
    obs.ended = end_cyc_i;
    obs.berr  = (end_kind_t'(end_kind_i) == END_BERR);
  end

  bown_next u_next (
    .cur_st (st_q),
    .obs    (obs),
    .nxt_st (nxt_st)
  );

  bown_drv u_drv (
    .clk      (clk),
    .rst      (rst),
    .nxt_st   (nxt_st),
    .st_q     (st_q),
    .bb_out_q (bb_out_o),
    .bb_oe_q  (bb_oe_o),
    .viol_q   (viol_o)
  );

  bown_arb_reg #(.REQ_STAGES(REQ_STAGES)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .ireq   (ireq_i),
    .bb_in  (bb_in_i),
    .bb_out (bb_out_o),
    .bb_oe  (bb_oe_o),
    .br     (br_o),
    .bb_sys (bb_sys_o)
  );

  assign state_o = st_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (state_o == 3'd0 && !bb_oe_o && !viol_o));

  // R2
  drive_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bb_oe_o) |-> $past(grant_i && ireq_i));

  // R5
  release_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && end_cyc_i && !grant_i && !bb_in_i) |=> (state_o == 3'd0));

  // R6
  berr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && end_cyc_i && grant_i && !bb_in_i && end_kind_i == 2'd1)
      |=> (state_o == 3'd2 && bb_oe_o));

  // R8
  viol_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && bb_in_i) |=> (viol_o && !bb_oe_o));

  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    viol_o |=> (viol_o && state_o == 3'd4));

endmodule

// File: tb/bus_own_tracker_tb_top.sv
module bus_own_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       grant_i = 1'b0, ireq_i = 1'b0, ts_in_i = 1'b0, bb_in_i = 1'b0, end_cyc_i = 1'b0;
  logic [1:0] end_kind_i = 2'd0;
  logic       bb_out_o, bb_oe_o, bb_sys_o, br_o, viol_o;
  logic [2:0] state_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // behavioural reference
  int    m_st = 0;
  bit    m_oe = 0;
  bit    m_viol = 0;
  bit    hist [STAGES];
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_own_tracker #(.REQ_STAGES(STAGES)) dut_i (
    .clk(clk), .rst(rst), .grant_i(grant_i), .ireq_i(ireq_i), .ts_in_i(ts_in_i),
    .bb_in_i(bb_in_i), .end_cyc_i(end_cyc_i), .end_kind_i(end_kind_i),
    .bb_out_o(bb_out_o), .bb_oe_o(bb_oe_o), .bb_sys_o(bb_sys_o), .br_o(br_o),
    .state_o(state_o), .viol_o(viol_o)
  );

  always @(posedge clk) begin
    int nx;
    string tg;
    bit g, rq, ts, bbi, e;
    g = grant_i; rq = ireq_i; ts = ts_in_i; bbi = bb_in_i; e = end_cyc_i;
    if (rst) begin
      nx = 0; tg = "R1";
      for (int i = 0; i < STAGES; i++) hist[i] = 0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = rq;
      nx = m_st; tg = "R3";
      case (m_st)
        0: if (g && rq && !bbi) begin nx = 2; tg = "R2"; end
           else if (g && !ts && !bbi) begin nx = 1; tg = "R3"; end
           else if (!g && ts) begin nx = 3; tg = "R4"; end
        1: begin
             tg = "R10";
             if (g && rq && !bbi) begin nx = 2; tg = "R2"; end
             else if (!g && ts) begin nx = 3; tg = "R4"; end
             else if (!g) nx = 0;
           end
        2: begin
             tg = "R7";
             if (bbi) begin nx = 4; tg = "R8"; end
             else if (e && !g) begin nx = 0; tg = "R5"; end
             else if (e && end_kind_i == 2'd1) begin nx = 2; tg = "R6"; end
             else if (e && !rq) nx = 1;
           end
        3: begin tg = "R9"; if (e) nx = g ? 1 : 0; end
        default: begin nx = 4; tg = "R8"; end
      endcase
    end
    m_st = nx; m_tag = tg;
    m_oe = (nx == 2); m_viol = (nx == 4);
  end

  task automatic chk1(string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d (t=%0t)", m_tag, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk1("state", int'(state_o), m_st);
    chk1("bb_oe", int'(bb_oe_o), int'(m_oe));
    chk1("bb_out", int'(bb_out_o), int'(m_oe));
    chk1("viol(R8)", int'(viol_o), int'(m_viol));
    chk1("br(R11)", int'(br_o), int'(hist[STAGES-1]));
    chk1("bb_sys(R12)", int'(bb_sys_o), int'(bb_in_i | m_oe));
  endtask

  task automatic cyc(bit g, bit rq, bit ts, bit bbi, bit e, logic [1:0] k);
    @(negedge clk);
    compare();
    grant_i = g; ireq_i = rq; ts_in_i = ts; bb_in_i = bbi; end_cyc_i = e; end_kind_i = k;
    rst = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    rst = 1'b1;
    grant_i = 0; ireq_i = 0; ts_in_i = 0; bb_in_i = 0; end_cyc_i = 0; end_kind_i = 0;
    @(negedge clk);
    compare();  // R1 reset state
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    // R3 park, R10 back to idle
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0); cyc(0,0,0,0,0,0); cyc(0,0,0,0,0,0);
    // R4 snoop, R9 stay then end with grant -> park
    cyc(0,0,1,0,0,0); cyc(0,0,0,0,0,0); cyc(1,0,0,0,1,0); cyc(1,0,0,0,0,0);
    // R2 park -> own, R6 bus error with grant holds
    cyc(1,1,0,0,0,0); cyc(1,1,0,0,1,1); cyc(1,0,0,0,1,1); cyc(1,1,0,0,0,0);
    // R7 normal end keep, retry end without request -> park
    cyc(1,1,0,0,1,0); cyc(1,0,0,0,1,2); cyc(1,1,0,0,0,0);
    // R5 release on kind 3 without grant, then bus error without grant
    cyc(0,1,0,0,1,3); cyc(1,1,0,0,0,0); cyc(0,0,0,0,1,1); cyc(0,0,0,0,0,0);
    // R8 violation, sticky under toggled inputs
    cyc(1,1,0,0,0,0); cyc(1,1,0,1,0,0); cyc(0,0,1,0,1,0); cyc(1,1,0,0,1,1);
    cyc(0,0,0,0,0,0); cyc(1,0,0,1,0,0);
    do_reset();
    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 59) == 0) do_reset();
      else cyc($urandom_range(0,3) != 0, $urandom_range(0,1) == 1, $urandom_range(0,3) == 0,
               $urandom_range(0,15) == 0, $urandom_range(0,2) == 0, 2'($urandom_range(0,3)));
    end
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired, got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule